// File: doc/BRIEF.md
# Eight-Bit Multi-Function Arithmetic-Logic Unit

This block is a purely combinational arithmetic-logic unit for byte-wide data. It takes two operands, a carry input and a four-bit operation code. It returns a low result byte, a high result byte and a set of flags, all settling from the present inputs with no clock. The operations are:

- bitwise logic;
- addition in unsigned, signed and carry-in forms;
- unsigned subtraction;
- signed and unsigned multiplication with a full sixteen-bit product;
- rotates and single-bit shifts;
- a conversion of four packed decimal digits, spread across both operands, into a binary value.

Beside the usual zero, carry, overflow and sign flags, the unit also reports two properties of the low result byte: whether it reads the same with its bits reversed, and whether it is a prime number. A summary flag is raised whenever zero, carry or overflow is set. The surrounding datapath registers the operands and results and picks which byte to expose.

Top module: `alu8_core`

## Requirements
- R1: Codes 0x0, 0x1, 0x2 and 0x3 put A AND B, A OR B, A XOR B and A XNOR B on the low byte; carry, overflow and sign read 0.
- R2: Code 0x4 puts A+B on the low byte, and its ninth bit on carry. Code 0x6 does the same with A+B+carry_in. Sign reads 0 for both.
- R3: Code 0x5 puts A+B on the low byte and sets overflow when both operands share a sign that differs from the sign of the sum. Sign equals bit 7 of the low byte.
- R4: Code 0x7 forms the signed product and code 0x8 the unsigned product, high byte on res_hi and low byte on res_lo. For code 0x7, sign equals bit 7 of the high byte; for code 0x8 it reads 0.
- R5: Code 0x9 puts A−B (mod 256) on the low byte, and carry reports a borrow, that is A < B as unsigned numbers.
- R6: Code 0xA rotates A left by one bit. Code 0xB shifts A left by one, inserts carry_in at bit 0 and sends the old bit 7 to carry.
- R7: Codes 0xC, 0xD and 0xE shift A by one bit: logical right, arithmetic right and logical left. Carry takes the bit shifted out.
  - Overflow is set only by code 0xE, when bit 7 of the result differs from bit 7 of A.
  - Sign equals bit 7 of the result for 0xD and 0xE, and reads 0 for 0xC.
- R8: Code 0xF reads {B,A} as four packed decimal digits. The weights are B[7:4] thousands, B[3:0] hundreds, A[7:4] tens and A[3:0] units. It returns the weighted sum, with each digit taken at its plain value, on {res_hi,res_lo}. Carry is set when any digit exceeds 9.
- R9: For every code other than 0x7, 0x8 and 0xF, res_hi is 0. Flags that a code does not define (as stated in R1 to R8) read 0, and sign reads 0 for code 0xF.
- R10: Zero is set exactly when all sixteen result bits are 0. The summary flag is zero OR carry OR overflow.
- R11: The palindrome flag is set when res_lo equals its own bit reversal.
- R12: The prime flag is set when res_lo, read as unsigned, is prime; 0 and 1 are not prime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand |
| carry_in | input | 1 | Carry input for codes 0x6 and 0xB |
| opcode | input | 4 | Operation select |
| res_lo | output | 8 | Low result byte |
| res_hi | output | 8 | High result byte |
| flag_zero | output | 1 | All result bits are zero |
| flag_carry | output | 1 | Carry, borrow, shifted-out bit or invalid digit |
| flag_ovf | output | 1 | Signed overflow |
| flag_any | output | 1 | OR of zero, carry and overflow |
| flag_pal | output | 1 | Low byte is a bit palindrome |
| flag_prime | output | 1 | Low byte is prime |
| flag_neg | output | 1 | Result is negative for signed codes |

## Verification
Some relations are checked by assertions whenever the inputs change:
- the high byte stays clear for single-byte codes;
- sign stays low for unsigned codes;
- overflow is raised only by the two codes allowed to raise it;
- a palindrome has equal end bits;
- a prime low byte is odd or equal to two;
- zero never coexists with prime or sign.

The exact arithmetic values, the borrow and shifted-out bits, decimal conversion with and without invalid digits, and the full prime and palindrome tables over all 256 byte values can only be shown by the bench's scenarios against its own reference model.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
// Package: operation codes and per-code classification helpers.
// Assumes a 4-bit code space with all 16 values defined.
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_AND  = 4'h0, OP_OR   = 4'h1, OP_XOR  = 4'h2, OP_XNOR = 4'h3,
        OP_ADDU = 4'h4, OP_ADDS = 4'h5, OP_ADDC = 4'h6, OP_MULS = 4'h7,
        OP_MULU = 4'h8, OP_SUBU = 4'h9, OP_ROL  = 4'hA, OP_RLC  = 4'hB,
        OP_LSR  = 4'hC, OP_ASR  = 4'hD, OP_LSL  = 4'hE, OP_BCD  = 4'hF
    } alu_op_e;

    // True for codes whose result spans both bytes.
    function automatic logic op_is_wide(input alu_op_e op);
        return (op == OP_MULS) || (op == OP_MULU) || (op == OP_BCD);
    endfunction

    // True for codes that may report a negative result.
    function automatic logic op_is_signed(input alu_op_e op);
        return (op == OP_ADDS) || (op == OP_MULS) || (op == OP_ASR) || (op == OP_LSL);
    endfunction

endpackage

// File: rtl/alu8_bcd.sv
`timescale 1ns/1ps
// Packed-decimal to binary converter.
// Reads 2*W/4 nibbles, most significant first, and accumulates value*10+digit.
// Assumes W is a multiple of 4; nibbles above 9 are weighted at face value
// and reported through dig_bad.
module alu8_bcd #(
    parameter int W = 8
) (
    input  logic [2*W-1:0] bcd_in,
    output logic [2*W-1:0] bin_out,
    output logic           dig_bad
);
    localparam int NDIG = (2 * W) / 4;

    // Horner accumulation over all digits plus invalid-digit detection.
    always_comb begin
        bin_out = '0;
        dig_bad = 1'b0;
        for (int k = NDIG - 1; k >= 0; k--) begin
            bin_out = bin_out * (2*W)'(10) + (2*W)'(bcd_in[4*k +: 4]);
            if (bcd_in[4*k +: 4] > 4'd9) dig_bad = 1'b1;
        end
    end
endmodule

// File: rtl/alu8_props.sv
`timescale 1ns/1ps
// Result-property detector: bit palindrome and primality of one W-bit value.
// Trial division by every constant divisor below 2**ceil(W/2) suffices,
// since any composite value below 2**W has a factor under its square root.
module alu8_props #(
    parameter int W = 8
) (
    input  logic [W-1:0] val,
    output logic         is_pal,
    output logic         is_prime
);
    localparam int DLIM = 2 ** ((W + 1) / 2);

    logic [W-1:0] rev;

    // Bit reversal built structurally.
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign rev[i] = val[W-1-i];
    end

    assign is_pal = (rev == val);

    // Prime test: at least 2 and no divisor strictly between 1 and the value.
    always_comb begin
        is_prime = (val >= W'(2));
        for (int d = 2; d < DLIM; d++) begin
            if ((W'(d) < val) && ((val % W'(d)) == '0)) is_prime = 1'b0;
        end
    end
endmodule

// File: rtl/alu8_exec.sv
`timescale 1ns/1ps
// Operation datapath: selects the result bytes and the carry, overflow and
// sign flags for the current code. Flags a code leaves undefined stay 0,
// and the high byte stays 0 for single-byte codes. The decimal conversion
// arrives precomputed from the converter.
module alu8_exec
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    input  alu_op_e        op,
    input  logic [2*W-1:0] bcd_val,
    input  logic           bcd_bad,
    output logic [W-1:0]   x,
    output logic [W-1:0]   y,
    output logic           cout,
    output logic           ovf,
    output logic           neg
);
    logic signed [2*W-1:0] smul;
    logic        [2*W-1:0] umul;

    // Full-width products, sign-extended or zero-extended beforehand.
    assign smul = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
    assign umul = {{W{1'b0}}, a} * {{W{1'b0}}, b};

    // Per-code result and flag selection.
    always_comb begin
        x    = '0;
        y    = '0;
        cout = 1'b0;
        ovf  = 1'b0;
        neg  = 1'b0;
        case (op)
            OP_AND:  x = a & b;
            OP_OR:   x = a | b;
            OP_XOR:  x = a ^ b;
            OP_XNOR: x = ~(a ^ b);
            OP_ADDU: {cout, x} = {1'b0, a} + {1'b0, b};
            OP_ADDS: begin
                x   = a + b;
                ovf = (a[W-1] == b[W-1]) && (x[W-1] != a[W-1]);
                neg = x[W-1];
            end
            OP_ADDC: {cout, x} = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
            OP_MULS: begin
                {y, x} = smul;
                neg    = y[W-1];
            end
            OP_MULU: {y, x} = umul;
            OP_SUBU: begin
                x    = a - b;
                cout = (a < b);
            end
            OP_ROL:  x = {a[W-2:0], a[W-1]};
            OP_RLC: begin
                x    = {a[W-2:0], cin};
                cout = a[W-1];
            end
            OP_LSR: begin
                x    = {1'b0, a[W-1:1]};
                cout = a[0];
            end
            OP_ASR: begin
                x    = {a[W-1], a[W-1:1]};
                cout = a[0];
                neg  = x[W-1];
            end
            OP_LSL: begin
                x    = {a[W-2:0], 1'b0};
                cout = a[W-1];
                ovf  = a[W-1] ^ a[W-2];
                neg  = x[W-1];
            end
            OP_BCD: begin
                {y, x} = bcd_val;
                cout   = bcd_bad;
            end
        endcase
    end

    // Single-byte codes keep the high byte clear (R9).
    always_comb begin
        if (!op_is_wide(op)) p_hi_clear_r9: assert (y == '0)
            else $error("high byte set for single-byte code");
    end

    // Unsigned codes never report a negative result (R9).
    always_comb begin
        if (!op_is_signed(op)) p_unsigned_pos_r9: assert (!neg)
            else $error("sign set for unsigned code");
    end

    // Overflow appears only on signed addition and left shift (R3, R7).
    always_comb begin
        if (ovf) p_ovf_source_r3: assert ((op == OP_ADDS) || (op == OP_LSL))
            else $error("overflow raised by wrong code");
    end
endmodule

// File: rtl/alu8_core.sv
`timescale 1ns/1ps
// Top of the combinational ALU: wires the decimal converter, the operation
// datapath and the property detector, and forms the zero and summary flags.
// Assumes no clock; every output follows the present inputs.
module alu8_core
    import alu8_pkg::*;
(
    input  logic [7:0] opnd_a,
    input  logic [7:0] opnd_b,
    input  logic       carry_in,
    input  logic [3:0] opcode,
    output logic [7:0] res_lo,
    output logic [7:0] res_hi,
    output logic       flag_zero,
    output logic       flag_carry,
    output logic       flag_ovf,
    output logic       flag_any,
    output logic       flag_pal,
    output logic       flag_prime,
    output logic       flag_neg
);
    localparam int W = 8;

    logic [2*W-1:0] bcd_val;
    logic           bcd_bad;
    alu_op_e        op;

    assign op = alu_op_e'(opcode);

    alu8_bcd #(.W(W)) u_bcd (
        .bcd_in  ({opnd_b, opnd_a}),
        .bin_out (bcd_val),
        .dig_bad (bcd_bad)
    );

    alu8_exec #(.W(W)) u_exec (
        .a       (opnd_a),
        .b       (opnd_b),
        .cin     (carry_in),
        .op      (op),
        .bcd_val (bcd_val),
        .bcd_bad (bcd_bad),
        .x       (res_lo),
        .y       (res_hi),
        .cout    (flag_carry),
        .ovf     (flag_ovf),
        .neg     (flag_neg)
    );

    alu8_props #(.W(W)) u_props (
        .val      (res_lo),
        .is_pal   (flag_pal),
        .is_prime (flag_prime)
    );

    assign flag_zero = ({res_hi, res_lo} == '0);
    assign flag_any  = flag_zero | flag_carry | flag_ovf;

    // A palindrome must have matching end bits (R11).
    always_comb begin
        if (flag_pal) p_pal_ends_r11: assert (res_lo[0] == res_lo[W-1])
            else $error("palindrome flag with unequal end bits");
    end

    // A prime byte is odd or exactly two (R12).
    always_comb begin
        if (flag_prime) p_prime_odd_r12: assert (res_lo[0] || (res_lo == 8'd2))
            else $error("prime flag on even value");
    end

    // A zero result is neither prime nor negative (R10).
    always_comb begin
        if (flag_zero) p_zero_plain_r10: assert (!flag_prime && !flag_neg)
            else $error("zero result with prime or sign flag");
    end
endmodule

// File: tb/test_alu8_core.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver applies operands after a rising edge and
// queues a reference result; the monitor compares at the falling edge.
module test_alu8_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] opnd_a = '0, opnd_b = '0;
    logic       carry_in = 1'b0;
    logic [3:0] opcode = '0;
    logic [7:0] res_lo, res_hi;
    logic       flag_zero, flag_carry, flag_ovf, flag_any, flag_pal, flag_prime, flag_neg;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [22:0] vec;   // {x,y,z,c,v,any,pal,prime,neg}
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #10 clk = ~clk;   // 50 MHz

    alu8_core i_alu8_core (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in), .opcode(opcode),
        .res_lo(res_lo), .res_hi(res_hi), .flag_zero(flag_zero),
        .flag_carry(flag_carry), .flag_ovf(flag_ovf), .flag_any(flag_any),
        .flag_pal(flag_pal), .flag_prime(flag_prime), .flag_neg(flag_neg)
    );

    // Primality by plain trial division over every candidate divisor.
    function automatic bit ref_prime(input int v);
        if (v < 2) return 0;
        for (int d = 2; d < v; d++) if (v % d == 0) return 0;
        return 1;
    endfunction

    function automatic bit ref_pal(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i] != v[7-i]) return 0;
        return 1;
    endfunction

    function automatic string op_tag(input int op);
        case (op)
            0, 1, 2, 3: return "R1";
            4, 6:       return "R2";
            5:          return "R3";
            7, 8:       return "R4";
            9:          return "R5";
            10, 11:     return "R6";
            12, 13, 14: return "R7";
            default:    return "R8";
        endcase
    endfunction

    // Reference model written from the requirement list.
    function automatic logic [22:0] ref_model(input int a, input int b, input int ci, input int op);
        int x = 0, y = 0, c = 0, v = 0, n = 0, r, sa, sb, d3, d2, d1, d0;
        sa = (a > 127) ? a - 256 : a;
        sb = (b > 127) ? b - 256 : b;
        case (op)
            0: x = a & b;
            1: x = a | b;
            2: x = a ^ b;
            3: x = (~(a ^ b)) & 255;
            4: begin r = a + b; x = r % 256; c = r / 256; end
            5: begin r = sa + sb; x = r & 255; v = (r > 127 || r < -128); n = x / 128; end
            6: begin r = a + b + ci; x = r % 256; c = r / 256; end
            7: begin r = (sa * sb) & 65535; x = r % 256; y = r / 256; n = y / 128; end
            8: begin r = a * b; x = r % 256; y = r / 256; end
            9: begin x = (a - b + 256) % 256; c = (a < b); end
            10: x = ((a * 2) % 256) + a / 128;
            11: begin x = ((a * 2) % 256) + ci; c = a / 128; end
            12: begin x = a / 2; c = a % 2; end
            13: begin x = a / 2 + (a & 128); c = a % 2; n = x / 128; end
            14: begin x = (a * 2) % 256; c = a / 128; v = ((x / 128) != (a / 128)); n = x / 128; end
            default: begin
                d3 = b / 16; d2 = b % 16; d1 = a / 16; d0 = a % 16;
                r = d3 * 1000 + d2 * 100 + d1 * 10 + d0;
                x = r % 256; y = r / 256;
                c = (d3 > 9 || d2 > 9 || d1 > 9 || d0 > 9);
            end
        endcase
        return {x[7:0], y[7:0], 1'(x == 0 && y == 0), 1'(c), 1'(v),
                1'((x == 0 && y == 0) || c != 0 || v != 0),
                ref_pal(x[7:0]), ref_prime(x), 1'(n)};
    endfunction

    // Driver: apply one vector just after a rising edge and queue its expectation.
    task automatic drive(input int a, input int b, input int ci, input int op, input string tag);
        item_t it;
        @(posedge clk);
        #2;
        opnd_a   = 8'(a);
        opnd_b   = 8'(b);
        carry_in = 1'(ci);
        opcode   = 4'(op);
        it.vec   = ref_model(a, b, ci, op);
        it.tag   = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare the settled outputs at each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                logic [22:0] act;
                it  = sb_q.pop_front();
                act = {res_lo, res_hi, flag_zero, flag_carry, flag_ovf, flag_any,
                       flag_pal, flag_prime, flag_neg};
                n_tests++;
                if (act !== it.vec) begin
                    n_fail++;
                    $display("FAIL %s (R9 R10 R11 R12 flags) op=%0h a=%02h b=%02h ci=%0b actual=%06h expected=%06h",
                             it.tag, opcode, opnd_a, opnd_b, carry_in, act, it.vec);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        #(20 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    int corner_a[8] = '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h01, 8'h55, 8'hC3, 8'h40};
    int corner_b[8] = '{8'h00, 8'hFF, 8'h80, 8'h01, 8'hFF, 8'hAA, 8'h3C, 8'h40};

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Idle inputs at start: AND of zeros gives zero result, zero flag set (R10, R12).
        drive(0, 0, 0, 0, "R10");

        // Every code on corner operands and on pseudo-random operands, both carry values.
        for (int op = 0; op < 16; op++) begin
            for (int k = 0; k < 8; k++) begin
                drive(corner_a[k], corner_b[k], k % 2, op, op_tag(op));
            end
            for (int k = 0; k < 24; k++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                drive(int'(lfsr[7:0]), int'(lfsr[15:8]), k % 2, op, op_tag(op));
            end
        end

        // R8: valid digits 1234 and 9999, an invalid digit, and all zeros.
        drive(8'h34, 8'h12, 0, 15, "R8");
        drive(8'h99, 8'h99, 0, 15, "R8");
        drive(8'h0A, 8'h00, 0, 15, "R8");
        drive(8'h00, 8'hF0, 1, 15, "R8");
        drive(8'h00, 8'h00, 0, 15, "R8");

        // R3: positive and negative signed overflow, and a non-overflowing mix.
        drive(8'h7F, 8'h01, 0, 5, "R3");
        drive(8'h80, 8'hFF, 0, 5, "R3");
        drive(8'h80, 8'h7F, 0, 5, "R3");

        // R5: equal operands (no borrow) and smaller minus larger (borrow).
        drive(8'h42, 8'h42, 0, 9, "R5");
        drive(8'h01, 8'h02, 0, 9, "R5");

        // R11 and R12: every byte value presented on the low result via A AND A.
        for (int v = 0; v < 256; v++) drive(v, v, 0, 0, "R11 R12");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule